// File: doc/BRIEF.md
# Dual-Mode Interval and Watchdog Timer

This block counts periods of an internal tick taken from the main oscillator clock. Depending on a mode bit, it acts in one of two ways. As an interval timer, it raises a single-cycle maskable interrupt request each time the selected interval elapses. As a watchdog, it raises a single-cycle reset request on each expiry. Once software selects watchdog mode, only a reset returns the block to interval mode. Software writes three things through strobed inputs: a mode register (a start bit and a watchdog-select bit), a 3-bit interval code, and an oscillator-mode bit. The oscillator-mode bit chooses whether the tick runs at the full oscillator rate or at half that rate.

Counting continues while the CPU is halted. It freezes during stop mode and whenever the CPU runs from the subsystem clock. The divide-by-two tick is a clock enable on the single clock domain. That divider runs freely and a register write does not reset it, so the first interval after a write can be one clock short. In interval mode, an expiry that arrives while the mask flag is set is not lost: it is held in a pending flag that software clears. The priority flag travels with each interrupt pulse.

Top module: `interval_watchdog_timer`

## Requirements
- R1: While running in interval mode with the mask clear, irq_o pulses high for exactly one clock, once every 2^L ticks, where L is the interval exponent of R3.
- R2: After reset the block does not count. A mode write with the start bit set starts counting and clears the count, so the next expiry comes exactly 2^L ticks after the write. A mode write with the start bit clear leaves counting and the count unchanged.
- R3: The interval code selects the exponent L. Codes 0 through 6 give L = BASE_LOG2 + code. Code 7 gives L = BASE_LOG2 + 8, so one step is skipped.
- R4: With the oscillator-mode bit at 1, one tick occurs every clock. With it at 0 (the reset value), one tick occurs every second clock, which doubles each interval measured in clocks.
- R5: A mode write with the watchdog bit set selects watchdog mode. In watchdog mode each expiry pulses wdog_rst_o for one clock and never raises irq_o. Later writes of 0 to the watchdog bit are ignored; only rst restores interval mode.
- R6: Asserting halt_i has no effect on counting. While stop_i is high the count holds, so the interval is stretched by exactly the number of stopped clocks.
- R7: While subclk_i is high the count holds, so the interval is stretched by exactly the number of suspended clocks.
- R8: An interval-mode expiry that occurs while mask_i is high produces no irq_o pulse and sets pend_o. pend_o stays high until a pend_clr_i pulse clears it. An expiry in the same clock as the clear takes precedence.
- R9: irq_prio_o is high in exactly those clocks where irq_o is high and prio_i was high at the expiry.
- R10: The half-rate tick divider is not reset by register writes, so in half-rate mode the first interval after a start write lasts 2*2^L - 1 or 2*2^L clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Write strobe for the mode register |
| mode_run_d | input | 1 | Start bit written with mode_we |
| mode_wdog_d | input | 1 | Watchdog-select bit written with mode_we |
| csel_we | input | 1 | Write strobe for the interval code |
| csel_d | input | 3 | Interval code |
| osc_we | input | 1 | Write strobe for the oscillator-mode bit |
| osc_full_d | input | 1 | 1 = full-rate tick, 0 = half-rate tick |
| halt_i | input | 1 | CPU halt status |
| stop_i | input | 1 | CPU stop status |
| subclk_i | input | 1 | CPU running on subsystem clock |
| mask_i | input | 1 | Interrupt mask flag |
| prio_i | input | 1 | Interrupt priority flag |
| pend_clr_i | input | 1 | Clears the pending flag |
| irq_o | output | 1 | Interval interrupt request pulse |
| irq_prio_o | output | 1 | Priority qualifier of irq_o |
| pend_o | output | 1 | Masked expiry pending |
| wdog_rst_o | output | 1 | Watchdog reset request pulse |

## Verification
The bench measures the clocks between two consecutive pulses, and from a start write to the first pulse. It does this for interval codes 0, 1, 6 and 7 at full rate, so a decode that failed to skip a step at code 7 would show up as a wrong period. It also measures code 0 at half rate, which separates the oscillator-mode divider from the interval decode. Stop and subsystem-clock windows of a known length must lengthen the gap by exactly that amount, while halt must leave the gap unchanged. Separate runs toggle the mask, the priority flag and the watchdog bit, so the three routes an expiry can take are each seen alone.

// File: rtl/iwt_pkg.sv
package iwt_pkg;

    typedef struct packed {
        logic       run;
        logic       wdog;
        logic [2:0] csel;
        logic       osc_full;
    } iwt_cfg_t;

    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_IRQ    = 2'd1,
        EV_MASKED = 2'd2,
        EV_WDOG   = 2'd3
    } iwt_evt_t;

    localparam int unsigned SKIP_CODE = 7;
    localparam int unsigned TOP_STEP  = 8;

    // Interval exponent for a code; the top code jumps one step further.
    function automatic int unsigned span_log2(input logic [2:0] code,
                                              input int unsigned base);
        if (int'(code) == SKIP_CODE)
            return base + TOP_STEP;
        return base + int'(code);
    endfunction

endpackage

// File: rtl/iwt_cfg_regs.sv
module iwt_cfg_regs
    import iwt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_we,
    input  logic       mode_run_d,
    input  logic       mode_wdog_d,
    input  logic       csel_we,
    input  logic [2:0] csel_d,
    input  logic       osc_we,
    input  logic       osc_full_d,
    output iwt_cfg_t   cfg,
    output logic       restart
);

    iwt_cfg_t cfg_q;

    assign restart = mode_we & mode_run_d;
    assign cfg     = cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            if (mode_we) begin
                // Both bits can only be set by software; reset clears them.
                cfg_q.run  <= cfg_q.run  | mode_run_d;
                cfg_q.wdog <= cfg_q.wdog | mode_wdog_d;
            end
            if (csel_we)
                cfg_q.csel <= csel_d;
            if (osc_we)
                cfg_q.osc_full <= osc_full_d;
        end
    end

    // R5: watchdog selection cannot be undone by a write
    p_wdog_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        cfg_q.wdog |=> cfg_q.wdog);

    // R2: a start write always leaves the block running
    p_run_after_start_r2: assert property (@(posedge clk) disable iff (rst)
        restart |=> cfg_q.run);

endmodule

// File: rtl/iwt_tick_gen.sv
module iwt_tick_gen (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic osc_full,
    input  logic halt_i,
    input  logic stop_i,
    input  logic subclk_i,
    output logic tick
);

    logic half_q;
    logic hold;

    // Free-running divider: never cleared by register writes.
    always_ff @(posedge clk) begin
        if (rst)
            half_q <= 1'b0;
        else
            half_q <= ~half_q;
    end

    // HALT keeps the timer alive; STOP and subsystem clock freeze it.
    always_comb begin
        hold = stop_i | subclk_i;
        tick = run & ~hold & (osc_full | half_q);
    end

    // R6: halt alone never blocks a full-rate tick of a running timer
    p_halt_runs_r6: assert property (@(posedge clk) disable iff (rst)
        (halt_i && run && osc_full && !stop_i && !subclk_i) |-> tick);

endmodule

// File: rtl/iwt_counter.sv
module iwt_counter
    import iwt_pkg::*;
#(
    parameter int unsigned BASE_LOG2 = 11,
    localparam int unsigned CW = BASE_LOG2 + TOP_STEP
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          tick,
    input  logic [2:0]    csel,
    output logic [CW-1:0] cnt,
    output logic          expire
);

    logic [CW-1:0] limit;
    int unsigned   span;

    always_comb begin
        span  = span_log2(csel, BASE_LOG2);
        limit = '0;
        for (int i = 0; i < CW; i++)
            if (i < int'(span))
                limit[i] = 1'b1;
        // >= so a lowered code expires at once instead of wrapping
        expire = tick & (cnt >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (expire)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end

    // R1: an expiry always restarts the count from zero
    p_wrap_zero_r1: assert property (@(posedge clk) disable iff (rst)
        expire |=> (cnt == '0));

endmodule

// File: rtl/interval_watchdog_timer.sv
module interval_watchdog_timer
    import iwt_pkg::*;
#(
    parameter int unsigned BASE_LOG2 = 11
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_we,
    input  logic       mode_run_d,
    input  logic       mode_wdog_d,
    input  logic       csel_we,
    input  logic [2:0] csel_d,
    input  logic       osc_we,
    input  logic       osc_full_d,
    input  logic       halt_i,
    input  logic       stop_i,
    input  logic       subclk_i,
    input  logic       mask_i,
    input  logic       prio_i,
    input  logic       pend_clr_i,
    output logic       irq_o,
    output logic       irq_prio_o,
    output logic       pend_o,
    output logic       wdog_rst_o
);

    localparam int unsigned CW = BASE_LOG2 + TOP_STEP;

    iwt_cfg_t      cfg;
    logic          restart;
    logic          tick;
    logic          expire;
    logic [CW-1:0] cnt;
    iwt_evt_t      evt;

    iwt_cfg_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .mode_we     (mode_we),
        .mode_run_d  (mode_run_d),
        .mode_wdog_d (mode_wdog_d),
        .csel_we     (csel_we),
        .csel_d      (csel_d),
        .osc_we      (osc_we),
        .osc_full_d  (osc_full_d),
        .cfg         (cfg),
        .restart     (restart)
    );

    iwt_tick_gen u_tick (
        .clk      (clk),
        .rst      (rst),
        .run      (cfg.run),
        .osc_full (cfg.osc_full),
        .halt_i   (halt_i),
        .stop_i   (stop_i),
        .subclk_i (subclk_i),
        .tick     (tick)
    );

    iwt_counter #(
        .BASE_LOG2 (BASE_LOG2)
    ) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr    (restart),
        .tick   (tick),
        .csel   (cfg.csel),
        .cnt    (cnt),
        .expire (expire)
    );

    // Route each expiry to exactly one destination.
    always_comb begin
        evt = EV_NONE;
        if (expire) begin
            if (cfg.wdog)
                evt = EV_WDOG;
            else if (mask_i)
                evt = EV_MASKED;
            else
                evt = EV_IRQ;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o      <= 1'b0;
            irq_prio_o <= 1'b0;
            wdog_rst_o <= 1'b0;
            pend_o     <= 1'b0;
        end else begin
            irq_o      <= (evt == EV_IRQ);
            irq_prio_o <= (evt == EV_IRQ) & prio_i;
            wdog_rst_o <= (evt == EV_WDOG);
            if (evt == EV_MASKED)
                pend_o <= 1'b1;
            else if (pend_clr_i)
                pend_o <= 1'b0;
        end
    end

    // R1: interrupt request is a single-cycle pulse
    p_irq_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> !irq_o);

    // R5: no interrupt request once watchdog mode was selected
    p_wdog_no_irq_r5: assert property (@(posedge clk) disable iff (rst)
        $past(cfg.wdog) |-> !irq_o);

    // R5: reset requests and interrupts never coincide
    p_wdog_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(irq_o && wdog_rst_o));

    // R6: stop freezes the count unless a start write clears it
    p_stop_freeze_r6: assert property (@(posedge clk) disable iff (rst)
        (stop_i && !restart) |=> $stable(cnt));

    // R7: subsystem clock freezes the count unless a start write clears it
    p_subclk_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        (subclk_i && !restart) |=> $stable(cnt));

    // R8: a masked expiry never produces an interrupt pulse
    p_irq_unmasked_r8: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(!mask_i));

    // R9: the priority qualifier only accompanies an interrupt
    p_prio_with_irq_r9: assert property (@(posedge clk) disable iff (rst)
        irq_prio_o |-> irq_o);

endmodule

// File: tb/test_interval_watchdog_timer.sv
module test_interval_watchdog_timer;

    localparam int unsigned BASE = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_we = 0, mode_run_d = 0, mode_wdog_d = 0;
    logic       csel_we = 0;
    logic [2:0] csel_d = 3'd0;
    logic       osc_we = 0, osc_full_d = 0;
    logic       halt_i = 0, stop_i = 0, subclk_i = 0;
    logic       mask_i = 0, prio_i = 0, pend_clr_i = 0;
    logic       irq_o, irq_prio_o, pend_o, wdog_rst_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    interval_watchdog_timer #(.BASE_LOG2(BASE)) i_interval_watchdog_timer (
        .clk(clk), .rst(rst),
        .mode_we(mode_we), .mode_run_d(mode_run_d), .mode_wdog_d(mode_wdog_d),
        .csel_we(csel_we), .csel_d(csel_d),
        .osc_we(osc_we), .osc_full_d(osc_full_d),
        .halt_i(halt_i), .stop_i(stop_i), .subclk_i(subclk_i),
        .mask_i(mask_i), .prio_i(prio_i), .pend_clr_i(pend_clr_i),
        .irq_o(irq_o), .irq_prio_o(irq_prio_o), .pend_o(pend_o),
        .wdog_rst_o(wdog_rst_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr_mode(input logic run, input logic wd);
        @(negedge clk);
        mode_we = 1; mode_run_d = run; mode_wdog_d = wd;
        @(negedge clk);
        mode_we = 0; mode_run_d = 0; mode_wdog_d = 0;
    endtask

    task automatic wr_csel(input logic [2:0] c);
        @(negedge clk);
        csel_we = 1; csel_d = c;
        @(negedge clk);
        csel_we = 0;
    endtask

    task automatic wr_osc(input logic f);
        @(negedge clk);
        osc_we = 1; osc_full_d = f;
        @(negedge clk);
        osc_we = 0;
    endtask

    // Counts negedges until the chosen output is seen high (which: 0 irq, 1 reset req).
    task automatic wait_evt(input bit which, input int limit,
                            output int n, output bit got_irq, output bit got_rst);
        n = 0; got_irq = 0; got_rst = 0;
        while (n < limit) begin
            @(negedge clk);
            n++;
            if (irq_o) got_irq = 1;
            if (wdog_rst_o) got_rst = 1;
            if ((which == 0 && irq_o) || (which == 1 && wdog_rst_o)) return;
        end
    endtask

    task automatic t_reset_state();
        int n; bit gi, gr;
        do_reset();
        check(irq_o == 0 && wdog_rst_o == 0 && pend_o == 0, "R2 reset outputs", 1, 0);
        wait_evt(0, 40, n, gi, gr);
        check(!gi && !gr, "R2 idle after reset", gi, 0);
        wr_osc(1);
    endtask

    task automatic t_first_and_period();
        int n; bit gi, gr;
        wr_mode(1, 0);
        wait_evt(0, 100, n, gi, gr);
        check(n == 4, "R2 first interval after start", n, 4);
        wait_evt(0, 100, n, gi, gr);
        check(n == 4, "R1 period code0", n, 4);
        wait_evt(0, 100, n, gi, gr);
        check(n == 4, "R1 period repeat", n, 4);
    endtask

    task automatic t_decode();
        int n; bit gi, gr;
        int codes [3] = '{1, 6, 7};
        int exps  [3] = '{8, 256, 1024};
        for (int i = 0; i < 3; i++) begin
            wr_csel(3'(codes[i]));
            wr_mode(1, 0);
            wait_evt(0, 3000, n, gi, gr);
            check(n == exps[i], "R3 interval per code", n, exps[i]);
        end
        wr_csel(3'd0);
    endtask

    task automatic t_half_rate();
        int n; bit gi, gr;
        wr_osc(0);
        wr_mode(1, 0);
        wait_evt(0, 100, n, gi, gr);
        check(n == 7 || n == 8, "R10 first half-rate interval", n, 8);
        wait_evt(0, 100, n, gi, gr);
        check(n == 8, "R4 half-rate period", n, 8);
        wr_osc(1);
        wr_mode(1, 0);
    endtask

    task automatic t_run_zero_and_restart();
        int n, k; bit gi, gr;
        wait_evt(0, 100, n, gi, gr);
        wr_mode(0, 0);
        wait_evt(0, 100, k, gi, gr);
        check(k + 2 == 4, "R2 start-clear write ignored", k + 2, 4);
        @(negedge clk);
        wr_mode(1, 0);
        wait_evt(0, 100, n, gi, gr);
        check(n == 4, "R2 restart mid-interval", n, 4);
    endtask

    task automatic t_halt_stop_sub();
        int n, m; bit gi, gr;
        halt_i = 1;
        wait_evt(0, 100, n, gi, gr);
        wait_evt(0, 100, n, gi, gr);
        check(n == 4, "R6 halt keeps counting", n, 4);
        halt_i = 0;
        stop_i = 1;
        m = 0;
        repeat (20) begin @(negedge clk); m++; end
        check(!irq_o, "R6 no expiry while stopped", irq_o, 0);
        stop_i = 0;
        wait_evt(0, 100, n, gi, gr);
        check(m + n == 24, "R6 stop stretches interval", m + n, 24);
        subclk_i = 1;
        m = 0;
        repeat (20) begin @(negedge clk); m++; end
        subclk_i = 0;
        wait_evt(0, 100, n, gi, gr);
        check(m + n == 24, "R7 subclk stretches interval", m + n, 24);
    endtask

    task automatic t_mask_pending();
        int n; bit gi, gr;
        mask_i = 1;
        wait_evt(0, 12, n, gi, gr);
        check(!gi, "R8 masked expiry gives no irq", gi, 0);
        check(pend_o == 1, "R8 pending set", pend_o, 1);
        stop_i = 1;
        @(negedge clk);
        pend_clr_i = 1;
        @(negedge clk);
        pend_clr_i = 0;
        check(pend_o == 0, "R8 pending cleared", pend_o, 0);
        stop_i = 0;
        mask_i = 0;
        wait_evt(0, 100, n, gi, gr);
        check(gi, "R8 irq returns when unmasked", gi, 1);
    endtask

    task automatic t_prio();
        int n; bit gi, gr;
        prio_i = 1;
        wait_evt(0, 100, n, gi, gr);
        check(irq_prio_o == 1, "R9 prio with irq", irq_prio_o, 1);
        prio_i = 0;
        wait_evt(0, 100, n, gi, gr);
        check(irq_prio_o == 0, "R9 no prio", irq_prio_o, 0);
    endtask

    task automatic t_watchdog();
        int n; bit gi, gr;
        wr_mode(1, 1);
        wait_evt(1, 100, n, gi, gr);
        check(gr && n == 4, "R5 watchdog reset request", n, 4);
        check(!gi, "R5 no irq in watchdog", gi, 0);
        wr_mode(1, 0);
        wait_evt(1, 100, n, gi, gr);
        check(gr && !gi, "R5 watchdog mode sticky", gr, 1);
        do_reset();
        wr_osc(1);
        wr_mode(1, 0);
        wait_evt(0, 100, n, gi, gr);
        check(gi && n == 4, "R5 reset restores interval mode", n, 4);
    endtask

    initial begin
        t_reset_state();
        t_first_and_period();
        t_decode();
        t_half_rate();
        t_run_zero_and_restart();
        t_halt_stop_sub();
        t_mask_pending();
        t_prio();
        t_watchdog();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog timeout actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule